// File: doc/BRIEF.md
# Serially Configured Sum-of-Products Array

This block is a small programmable logic array that can be reconfigured while the chip runs. It takes four data inputs and offers each one to eight product terms in both true and inverted form. Each of four outputs is the OR of any chosen subset of those terms. A per-output select bit picks either the combinational sum or a flip-flop copy of it taken at the last rising clock edge, so the array can also serve as a registered, sequential stage.

The whole configuration is a 100-bit word. A one-bit serial port loads it, one bit per clock while `cfg_en` is high. The word holds 64 AND-plane bits, then 32 OR-plane bits, then 4 output-select bits. The configuration registers serve directly as the planes, so there is no separate shadow copy.

A small controller tracks the load with three states:
- `CFG_IDLE`: not configured.
- `CFG_LOAD`: counting bits.
- `CFG_RUN`: fully loaded.

The transitions are:
- `CFG_IDLE` goes to `CFG_LOAD` on the first enabled bit.
- `CFG_LOAD` stays in `CFG_LOAD` while bits arrive or while the port pauses.
- `CFG_LOAD` goes to `CFG_RUN` on the 100th enabled bit.
- `CFG_RUN` goes back to `CFG_LOAD` on any new enabled bit, which starts a fresh load.
- Synchronous reset returns the controller to `CFG_IDLE` from any state.

Outputs stay at 0 whenever the controller is not in `CFG_RUN`.

Top module: `pla_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the configuration, the bit count and the output flip-flops. After reset, `cfg_done` = 0 and `out_vec` = 0.
- R2: `cfg_done` rises right after the rising edge that takes the 100th bit with `cfg_en` high. After 99 bits it is still 0. Cycles with `cfg_en` low shift nothing and do not count.
- R3: Bits enter MSB-first, so the first bit sent ends up at bit 99 of the configuration word C.
  - C[36 + 8t + 2i] connects the true form of `in_vec[i]` to term t.
  - C[36 + 8t + 2i + 1] connects the inverted form of `in_vec[i]` to term t.
  - C[4 + 8o + t] connects term t to output o.
  - C[o] = 1 makes output o registered.
  - The configuration does not change while `cfg_en` is low.
- R4: A product term is the AND of its connected literals. A term with no literals connected is 1.
- R5: A term that has both the true and the inverted form of the same input connected is 0.
- R6: Each output's sum is the OR of the terms connected to it. An output with no terms connected gives 0.
- R7: When output o has select 0, `out_vec[o]` follows `in_vec` with no clock edge in between.
- R8: When output o has select 1, `out_vec[o]` shows the sum captured at the last rising edge. The capture at the edge that completes a load gives 0.
- R9: While `cfg_done` is 0, `out_vec` is 0. An enabled bit in `CFG_RUN` drops `cfg_done` and starts a new 100-bit load.
- R10: With in_vec = {w,x,y,z} (w = bit 3), the array can be loaded to give both functions on all 16 input combinations:
  - `out_vec[0]` = w·x'·y'·z + w·x·y'·z' + w'·x'·y
  - `out_vec[1]` = w·x·y' + x'·y'·z'

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| in_vec | input | 4 | Logic inputs |
| out_vec | output | 4 | Array outputs, combinational or registered per select bit |
| cfg_done | output | 1 | High while a complete configuration is loaded |

## Verification
An off-by-one in the bit count shows one cycle early or late on `cfg_done`. It also shifts every field by one position, so nearly every output value across the 16-combination sweep goes wrong in the first cycles after the load. A wrong literal or OR connection changes the outputs for specific input patterns as soon as those inputs are applied. A stale or badly gated output flip-flop shows on the registered outputs one edge after the input change, or in the first cycle after the load.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_LOAD = 2'd1,
        CFG_RUN  = 2'd2
    } cfg_state_t;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_en,
    input  logic                                 cfg_bit,
    output logic [2*N_IN*N_TERM-1:0]             and_sel,
    output logic [N_TERM*N_OUT-1:0]              or_sel,
    output logic [N_OUT-1:0]                     reg_sel,
    output logic                                 done
);
    localparam int AND_W = 2 * N_IN * N_TERM;
    localparam int OR_W  = N_TERM * N_OUT;
    localparam int TOTAL = AND_W + OR_W + N_OUT;
    localparam int CW    = $clog2(TOTAL + 1);

    cfg_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [TOTAL-1:0] chain_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CFG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CFG_IDLE: begin
                if (cfg_en) begin
                    cnt_d   = CW'(1);
                    state_d = CFG_LOAD;
                end
            end
            CFG_LOAD: begin
                if (cfg_en) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == CW'(TOTAL - 1)) begin
                        state_d = CFG_RUN;
                    end
                end
            end
            CFG_RUN: begin
                if (cfg_en) begin
                    cnt_d   = CW'(1);
                    state_d = CFG_LOAD;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = CFG_IDLE;
            end
        endcase
    end

    // serial chain, MSB first
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (cfg_en) begin
            chain_q <= {chain_q[TOTAL-2:0], cfg_bit};
        end
    end

    // outputs
    always_comb begin
        done    = (state_q == CFG_RUN);
        and_sel = chain_q[TOTAL-1 -: AND_W];
        or_sel  = chain_q[N_OUT +: OR_W];
        reg_sel = chain_q[N_OUT-1:0];
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == CFG_LOAD && cfg_en && cnt_q == CW'(TOTAL - 1)) |=> done); // R2
    AST_DONE_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(cfg_en)); // R2
    AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(chain_q)); // R3
    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_en) |=> !done); // R9
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_IN-1:0]              in_vec,
    input  logic [2*N_IN*N_TERM-1:0]     and_sel,
    output logic [N_TERM-1:0]            prod
);
    localparam int LW = 2 * N_IN;

    logic [LW-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = in_vec[i];
            lits[2*i+1] = ~in_vec[i];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign prod[t] = &(lits | ~and_sel[t*LW +: LW]);

        AST_EMPTY_TERM_ONE: assert property (@(posedge clk) disable iff (rst)
            (and_sel[t*LW +: LW] == '0) |-> prod[t]); // R4

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            AST_CONTRA_TERM_ZERO: assert property (@(posedge clk) disable iff (rst)
                (and_sel[t*LW + 2*i] && and_sel[t*LW + 2*i + 1]) |-> !prod[t]); // R5
        end
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]        prod,
    input  logic [N_TERM*N_OUT-1:0]  or_sel,
    output logic [N_OUT-1:0]         sum
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sum[o] = |(prod & or_sel[o*N_TERM +: N_TERM]);
    end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec,
    output logic             cfg_done
);
    localparam int AND_W = 2 * N_IN * N_TERM;
    localparam int OR_W  = N_TERM * N_OUT;

    logic [AND_W-1:0]  and_sel;
    logic [OR_W-1:0]   or_sel;
    logic [N_OUT-1:0]  reg_sel;
    logic [N_TERM-1:0] prod_w;
    logic [N_OUT-1:0]  sum_w;
    logic [N_OUT-1:0]  reg_q;

    pla_cfg_chain #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .and_sel (and_sel),
        .or_sel  (or_sel),
        .reg_sel (reg_sel),
        .done    (cfg_done)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk     (clk),
        .rst     (rst),
        .in_vec  (in_vec),
        .and_sel (and_sel),
        .prod    (prod_w)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .prod   (prod_w),
        .or_sel (or_sel),
        .sum    (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= cfg_done ? sum_w : '0;
        end
    end

    always_comb begin
        out_vec = cfg_done ? ((sum_w & ~reg_sel) | (reg_q & reg_sel)) : '0;
    end

    AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> (out_vec == '0)); // R9
    AST_REG_LAGS_SUM: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && $past(cfg_done) && $stable(reg_sel))
        |-> ((out_vec & reg_sel) == ($past(sum_w) & reg_sel))); // R8
endmodule

// File: tb/tb_pla_array.sv
module tb_pla_array;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [3:0] in_vec = 4'd0;
    logic [3:0] out_vec;
    logic       cfg_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    logic [99:0] m_cfg = '0;
    int          m_cnt = 0;
    bit          m_done = 0;
    logic [3:0]  m_reg = '0;

    pla_array dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .in_vec(in_vec), .out_vec(out_vec), .cfg_done(cfg_done)
    );

    always #5 clk = ~clk;

    function automatic int lit_idx(int t, int i, int comp);
        return 36 + 8*t + 2*i + comp;
    endfunction

    function automatic logic [3:0] msum(logic [99:0] c, logic [3:0] x);
        logic [3:0] r = '0;
        for (int o = 0; o < 4; o++) begin
            for (int t = 0; t < 8; t++) begin
                if (c[4 + 8*o + t]) begin
                    bit term = 1;
                    for (int i = 0; i < 4; i++) begin
                        if (c[lit_idx(t, i, 0)] && !x[i]) term = 0;
                        if (c[lit_idx(t, i, 1)] && x[i]) term = 0;
                    end
                    if (term) r[o] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] m_out(logic [3:0] x);
        logic [3:0] s = msum(m_cfg, x);
        if (!m_done) return 4'd0;
        return (s & ~m_cfg[3:0]) | (m_reg & m_cfg[3:0]);
    endfunction

    function automatic bit f1(logic [3:0] v);
        bit w = v[3], x = v[2], y = v[1], z = v[0];
        return (w & ~x & ~y & z) | (w & x & ~y & ~z) | (~w & ~x & y);
    endfunction

    function automatic bit f2(logic [3:0] v);
        bit w = v[3], x = v[2], y = v[1], z = v[0];
        return (w & x & ~y) | (~x & ~y & ~z);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, advance model at the edge, compare at the falling edge
    task automatic cycle(logic en, logic b, logic [3:0] x, string tag);
        cfg_en = en;
        cfg_bit = b;
        in_vec = x;
        @(posedge clk);
        if (rst) begin
            m_cfg = '0; m_cnt = 0; m_done = 0; m_reg = '0;
        end else begin
            m_reg = m_done ? msum(m_cfg, x) : 4'd0;
            if (en) begin
                m_cfg = {m_cfg[98:0], b};
                if (m_done) begin
                    m_done = 0;
                    m_cnt = 1;
                end else begin
                    m_cnt++;
                end
                if (m_cnt == 100) m_done = 1;
            end
        end
        @(negedge clk);
        chk(tag, {27'd0, cfg_done, out_vec}, {27'd0, m_done, m_out(in_vec)});
    endtask

    task automatic load_cfg(logic [99:0] v, int pause_at);
        for (int k = 99; k >= 0; k--) begin
            if (k == pause_at) begin
                for (int p = 0; p < 3; p++) cycle(1'b0, 1'b1, 4'b0101, "R2");
            end
            cycle(1'b1, v[k], 4'b0101, "R3");
            if (k == 1) chk("R2", {31'd0, cfg_done}, 32'd0);
        end
        chk("R2", {31'd0, cfg_done}, 32'd1);
    endtask

    function automatic logic [99:0] base_planes();
        logic [99:0] c = '0;
        // w=3 x=2 y=1 z=0; comp 1 = inverted
        c[lit_idx(0,3,0)] = 1; c[lit_idx(0,2,1)] = 1; c[lit_idx(0,1,1)] = 1; c[lit_idx(0,0,0)] = 1;
        c[lit_idx(1,3,0)] = 1; c[lit_idx(1,2,0)] = 1; c[lit_idx(1,1,1)] = 1; c[lit_idx(1,0,1)] = 1;
        c[lit_idx(2,3,1)] = 1; c[lit_idx(2,2,1)] = 1; c[lit_idx(2,1,0)] = 1;
        c[lit_idx(3,3,0)] = 1; c[lit_idx(3,2,0)] = 1; c[lit_idx(3,1,1)] = 1;
        c[lit_idx(4,2,1)] = 1; c[lit_idx(4,1,1)] = 1; c[lit_idx(4,0,1)] = 1;
        // term 5 left empty, term 6 contradictory on z
        c[lit_idx(6,0,0)] = 1; c[lit_idx(6,0,1)] = 1;
        // out0 = t0|t1|t2, out1 = t3|t4
        c[4 + 0 + 0] = 1; c[4 + 0 + 1] = 1; c[4 + 0 + 2] = 1;
        c[4 + 8 + 3] = 1; c[4 + 8 + 4] = 1;
        return c;
    endfunction

    initial begin
        logic [99:0] cfg_a, cfg_b;
        cfg_a = base_planes();
        cfg_a[4 + 16 + 5] = 1;            // out2 = empty term
        cfg_a[4 + 24 + 6] = 1;            // out3 = contradictory term
        cfg_b = base_planes();
        cfg_b[4 + 24 + 3] = 1; cfg_b[4 + 24 + 4] = 1; // out3 = F2, out2 no terms
        cfg_b[3:0] = 4'b1010;             // out1, out3 registered

        // R1: reset state
        rst = 1'b1;
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 4'hF, "R1");
        rst = 1'b0;
        chk("R1", {28'd0, cfg_done, out_vec[2:0]}, 32'd0);

        // R2/R3: load config A with a pause
        load_cfg(cfg_a, 40);

        // R10/R4/R5: full truth table, combinational outputs
        for (int v = 0; v < 16; v++) begin
            cycle(1'b0, 1'b0, 4'(v), "R10");
            chk("R10", {31'd0, out_vec[0]}, {31'd0, f1(4'(v))});
            chk("R10", {31'd0, out_vec[1]}, {31'd0, f2(4'(v))});
            chk("R4",  {31'd0, out_vec[2]}, 32'd1);
            chk("R5",  {31'd0, out_vec[3]}, 32'd0);
        end

        // R7: combinational follow without a clock edge
        in_vec = 4'b1001; #1;
        chk("R7", {31'd0, out_vec[0]}, 32'd1);
        in_vec = 4'b0000; #1;
        chk("R7", {30'd0, out_vec[1:0]}, 32'd2);

        // R9: a new enabled bit in run drops done
        load_cfg(cfg_b, 60);
        // R8: capture at the completing edge gave 0
        chk("R8", {30'd0, out_vec[3], out_vec[1]}, 32'd0);
        for (int v = 0; v < 16; v++) begin
            cycle(1'b0, 1'b0, 4'(v), "R8");
            in_vec = ~4'(v); #1;
            chk("R8", {31'd0, out_vec[1]}, {31'd0, f2(4'(v))});
            chk("R8", {31'd0, out_vec[3]}, {31'd0, f2(4'(v))});
            chk("R7", {31'd0, out_vec[0]}, {31'd0, f1(~4'(v))});
            chk("R6", {31'd0, out_vec[2]}, 32'd0);
        end

        // R9: restart drops done and holds outputs low
        cycle(1'b1, 1'b0, 4'b1001, "R9");
        chk("R9", {27'd0, cfg_done, out_vec}, 32'd0);

        // R1: reset from the middle of a load
        rst = 1'b1;
        cycle(1'b0, 1'b0, 4'b1001, "R1");
        rst = 1'b0;
        cycle(1'b0, 1'b0, 4'b1001, "R1");
        chk("R1", {27'd0, cfg_done, out_vec}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule